// File: doc/BRIEF.md
# Console Terminal Register Block

This block gives a processor a memory-mapped console terminal with four 16-bit registers: receiver status, receiver buffer, transmitter status and transmitter buffer. The host issues one bus cycle per clock: a word read, a word write, a byte write or a bus reset. Read data and the address-error response come back combinationally in the same cycle. All register side effects take place at the clock edge that ends the cycle.

On the line side, a received character arrives as a byte with a valid strobe. It is accepted only while software has requested one character by setting the reader-enable bit. Characters that software writes to the transmitter buffer leave as a 7-bit code with a one-cycle valid strobe. The transmitter never stalls. The receive interrupt is a level signal. The transmit interrupt is a one-cycle request. Both use a fixed priority and vector, which the block presents as constant outputs.

Top module: `con_term_regs`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `rx_req`, `tx_valid`, `tx_irq` and `rx_irq` are 0. The receiver status then reads 0x0000 and the transmitter status reads 0x0080.
- R2: `bus_addr[2:1]` selects the register: 0 is receiver status, 1 is receiver buffer, 2 is transmitter status, 3 is transmitter buffer. Word cycles ignore `bus_addr[0]`. Cycle codes on `bus_cyc` are 0 for a word read, 1 for a word write, 2 for a byte write and 3 for a bus reset.
- R3: A receiver status read returns bit 7 = done, bit 6 = receive interrupt enable, and all other bits 0. A write loads the enable from bit 6. Writing bit 0 as 1 sets the pending request, which appears on `rx_req` from the next cycle.
- R4: A character on `rx_data` with `rx_valid` high is accepted only while the request is pending. It is latched, done is set and the request is cleared. When no request is pending, the character changes nothing.
- R5: A receiver buffer read returns the latched character zero-extended to 16 bits and clears done. If a character is accepted in the same cycle, done stays set.
- R6: `rx_irq` is high exactly while done and the receive interrupt enable are both 1.
- R7: A transmitter status read returns bit 7 = 1 and bit 6 = transmit interrupt enable. A write loads the enable from bit 6. A write that moves the enable from 0 to 1 gives a one-cycle `tx_irq` in the next cycle.
- R8: A transmitter buffer write keeps bits 6:0. Unless that code is 0x7F, `tx_valid` pulses in the next cycle with it on `tx_data`, and `tx_irq` pulses too if the transmit enable was 1. A code of 0x7F gives neither pulse.
- R9: A byte write puts `bus_wdata[7:0]` into the high byte when `bus_addr[0]` is 1 and into the low byte otherwise. The other byte comes from the register's current read value (0 for the transmitter buffer). The result is then applied as a word write.
- R10: A bus reset cycle clears done, the receive interrupt enable and the pending request, whatever the address. It leaves the transmit enable and the latched character unchanged and gives no error.
- R11: `bus_err` is high in the same cycle, with `bus_rdata` 0 and no side effect, for: any non-reset cycle with `bus_addr` of 8 or more; any write to the receiver buffer; any read of the transmitter buffer.
- R12: `irq_pri` reads 4 and `irq_vec` reads octal 064 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | A bus cycle is present this clock |
| bus_cyc | input | 2 | Cycle kind: 0 word read, 1 word write, 2 byte write, 3 bus reset |
| bus_addr | input | ADDR_W | Byte offset from the device base |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 16 | Read data, valid in the cycle of a word read |
| bus_err | output | 1 | Address-error response for the current cycle |
| rx_data | input | DATA_W | Received character |
| rx_valid | input | 1 | Received character strobe |
| rx_req | output | 1 | One character is requested |
| tx_data | output | CHAR_W | Character to send |
| tx_valid | output | 1 | Send strobe, one cycle |
| rx_irq | output | 1 | Receive interrupt request (level) |
| tx_irq | output | 1 | Transmit interrupt request (one-cycle pulse) |
| irq_pri | output | 3 | Interrupt priority |
| irq_vec | output | 9 | Interrupt vector |

## Verification
A reference model in the bench is compared with every output on every clock. It is driven by four kinds of pattern:
- Directed receive traffic, with characters sent both with and without a pending request. This separates accepted characters from ignored ones.
- Transmitter writes of ordinary codes, of 0x7F, and of 0xFF, whose upper bit must be stripped before the drop test. These separate the drop rule from plain masking. Repeated enable writes separate an edge-triggered interrupt from a level one.
- Byte writes to both lanes of every register. These show whether the other byte is merged or clobbered.
- A long stream of arbitrary cycles, addresses and line characters. It reaches the collisions: a read or reset in the same cycle as an arrival.

// File: rtl/con_term_pkg.sv
// Shared definitions for the console terminal register block.
// Assumes the word-select field is bus_addr[2:1].
package con_term_pkg;
    typedef enum logic [1:0] {
        CYC_RD16 = 2'd0,
        CYC_WR16 = 2'd1,
        CYC_WR8  = 2'd2,
        CYC_RST  = 2'd3
    } bus_cyc_e;

    localparam int BIT_DONE = 7;
    localparam int BIT_IE   = 6;
    localparam int BIT_GO   = 0;

    localparam logic [1:0] SEL_RSTAT = 2'd0;
    localparam logic [1:0] SEL_RBUF  = 2'd1;
    localparam logic [1:0] SEL_TSTAT = 2'd2;
    localparam logic [1:0] SEL_TBUF  = 2'd3;
endpackage

// File: rtl/con_term_rx.sv
// Receiver side: holds the done flag, the interrupt enable, the pending
// one-character request and the last accepted character.
// Assumes at most one register access per cycle; the decoder qualifies
// every strobe.
module con_term_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              stat_wr,
    input  logic              stat_ie,
    input  logic              stat_go,
    input  logic              buf_rd,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              done,
    output logic              ie,
    output logic              pending,
    output logic [DATA_W-1:0] rbuf
);
    logic take;
    assign take = rx_valid && pending;

    // Purpose: update receiver state from bus strobes and line arrivals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            ie      <= 1'b0;
            pending <= 1'b0;
            rbuf    <= '0;
        end else if (bus_rst) begin
            done    <= 1'b0;
            ie      <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (take) begin
                rbuf    <= rx_data;
                done    <= 1'b1;
                pending <= 1'b0;
            end else if (buf_rd) begin
                done <= 1'b0;
            end
            if (stat_wr) begin
                ie <= stat_ie;
                if (stat_go) begin
                    pending <= 1'b1;
                end
            end
        end
    end

    p_take_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bus_rst && !stat_wr) |=> (done && !pending));

    p_done_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(pending));

    p_bus_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (!done && !ie && !pending));
endmodule

// File: rtl/con_term_tx.sv
// Transmitter side: holds the interrupt enable and produces the send
// strobe and the one-cycle interrupt request.
// Assumes stat_wr and buf_wr are never high together.
module con_term_tx #(
    parameter int CHAR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic              stat_ie,
    input  logic              buf_wr,
    input  logic [CHAR_W-1:0] buf_code,
    output logic              tie,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_irq
);
    localparam logic [CHAR_W-1:0] DROP_CODE = '1;

    logic send;
    assign send = buf_wr && (buf_code != DROP_CODE);

    // Purpose: register the enable, the send pulse and the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tie      <= 1'b0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_irq   <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            tx_irq   <= 1'b0;
            if (stat_wr) begin
                tie    <= stat_ie;
                tx_irq <= stat_ie && !tie;
            end
            if (send) begin
                tx_valid <= 1'b1;
                tx_data  <= buf_code;
                tx_irq   <= tie;
            end
        end
    end

    p_enable_edge_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tie) |-> tx_irq);

    p_drop_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && buf_code == DROP_CODE) |=> (!tx_valid && !tx_irq));
endmodule

// File: rtl/con_term_regs.sv
// Console terminal register block top: decodes the bus cycle, merges
// byte writes into the current register value, and returns read data
// and the address-error response combinationally.
// Assumes ADDR_W >= 4 and one bus cycle per clock.
module con_term_regs #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int CHAR_W  = 7,
    parameter int IRQ_PRI = 4,
    parameter int IRQ_VEC = 'o64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic [1:0]        bus_cyc,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_err,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_req,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic [2:0]        irq_pri,
    output logic [8:0]        irq_vec
);
    import con_term_pkg::*;

    bus_cyc_e   cyc;
    logic [1:0] word_sel;
    logic       in_range, is_rd, is_wr, is_wr8, is_rst, acc_ok;
    logic       rx_done, rx_ie, tx_ie;
    logic [DATA_W-1:0] rx_buf;
    logic [15:0] cur_word, merged, wr_word;

    assign cyc      = bus_cyc_e'(bus_cyc);
    assign word_sel = bus_addr[2:1];
    assign in_range = (bus_addr[ADDR_W-1:3] == '0);
    assign is_rst   = bus_req && (cyc == CYC_RST);
    assign is_rd    = (cyc == CYC_RD16);
    assign is_wr8   = (cyc == CYC_WR8);
    assign is_wr    = (cyc == CYC_WR16) || is_wr8;

    // Purpose: flag undecoded offsets and the wrong direction at a buffer.
    always_comb begin
        bus_err = 1'b0;
        if (bus_req && !is_rst) begin
            bus_err = !in_range
                   || (word_sel == SEL_RBUF && !is_rd)
                   || (word_sel == SEL_TBUF && is_rd);
        end
    end
    assign acc_ok = bus_req && !is_rst && !bus_err;

    // Purpose: form the current read value of the selected register.
    always_comb begin
        cur_word = '0;
        unique case (word_sel)
            SEL_RSTAT: begin
                cur_word[BIT_DONE] = rx_done;
                cur_word[BIT_IE]   = rx_ie;
            end
            SEL_RBUF:  cur_word = 16'(rx_buf);
            SEL_TSTAT: begin
                cur_word[BIT_DONE] = 1'b1;
                cur_word[BIT_IE]   = tx_ie;
            end
            default:   cur_word = '0;
        endcase
    end

    // Purpose: merge a byte write into the unaddressed byte.
    always_comb begin
        if (bus_addr[0]) merged = {bus_wdata[7:0], cur_word[7:0]};
        else             merged = {cur_word[15:8], bus_wdata[7:0]};
        wr_word = is_wr8 ? merged : bus_wdata;
    end

    assign bus_rdata = (acc_ok && is_rd) ? cur_word : 16'h0000;

    con_term_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rst  (is_rst),
        .stat_wr  (acc_ok && is_wr && word_sel == SEL_RSTAT),
        .stat_ie  (wr_word[BIT_IE]),
        .stat_go  (wr_word[BIT_GO]),
        .buf_rd   (acc_ok && is_rd && word_sel == SEL_RBUF),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .done     (rx_done),
        .ie       (rx_ie),
        .pending  (rx_req),
        .rbuf     (rx_buf)
    );

    con_term_tx #(.CHAR_W(CHAR_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_wr  (acc_ok && is_wr && word_sel == SEL_TSTAT),
        .stat_ie  (wr_word[BIT_IE]),
        .buf_wr   (acc_ok && is_wr && word_sel == SEL_TBUF),
        .buf_code (wr_word[CHAR_W-1:0]),
        .tie      (tx_ie),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_irq   (tx_irq)
    );

    assign rx_irq  = rx_done && rx_ie;
    assign irq_pri = 3'(IRQ_PRI);
    assign irq_vec = 9'(IRQ_VEC);

    p_err_no_send_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !tx_valid);

    p_err_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 16'h0000));
endmodule

// File: tb/con_term_regs_bench.sv
// Bench for con_term_regs: a behavioural reference model compared with
// the outputs on every clock.
module con_term_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic [1:0]  bus_cyc = 2'd0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_valid = 1'b0;
    logic        rx_req;
    logic [6:0]  tx_data;
    logic        tx_valid, rx_irq, tx_irq;
    logic [2:0]  irq_pri;
    logic [8:0]  irq_vec;

    con_term_regs u_con_term_regs (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_cyc(bus_cyc),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_req(rx_req), .tx_data(tx_data), .tx_valid(tx_valid),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .irq_pri(irq_pri), .irq_vec(irq_vec)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    int m_done = 0, m_ie = 0, m_pend = 0, m_rbuf = 0, m_tie = 0;
    int e_txv = 0, e_txd = 0, e_txirq = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int cur_val(input int sel);
        case (sel)
            0: return (m_done << 7) | (m_ie << 6);
            1: return m_rbuf;
            2: return 'h80 | (m_tie << 6);
            default: return 0;
        endcase
    endfunction

    // One clock: drive, check combinational response, step model, check registered outputs.
    task automatic cyc1(input int req, input int cyc, input int addr, input int wd,
                        input int rxv, input int rxd);
        int sel, err, ok, rd, wr, w, rst;
        @(negedge clk);
        bus_req = req[0]; bus_cyc = cyc[1:0]; bus_addr = addr[3:0];
        bus_wdata = wd[15:0]; rx_valid = rxv[0]; rx_data = rxd[7:0];
        #1;
        sel = (addr >> 1) & 3;
        rst = req && cyc == 3;
        rd  = (cyc == 0);
        wr  = (cyc == 1 || cyc == 2);
        err = req && !rst && (addr >= 8 || (sel == 1 && !rd) || (sel == 3 && rd));
        ok  = req && !rst && !err;
        chk("R11 err", bus_err, err);
        chk("R2/R3/R5/R7 rdata", bus_rdata, (ok && rd) ? cur_val(sel) : 0);
        if (cyc == 2)
            w = (addr & 1) ? (((wd & 'hFF) << 8) | (cur_val(sel) & 'hFF))
                           : ((cur_val(sel) & 'hFF00) | (wd & 'hFF));
        else
            w = wd;
        @(posedge clk);
        e_txv = 0; e_txirq = 0;
        if (rst) begin
            m_done = 0; m_ie = 0; m_pend = 0;
        end else begin
            if (rxv && m_pend) begin
                m_rbuf = rxd; m_done = 1; m_pend = 0;
            end else if (ok && rd && sel == 1) m_done = 0;
            if (ok && wr && sel == 0) begin
                m_ie = (w >> 6) & 1;
                if (w & 1) m_pend = 1;
            end
            if (ok && wr && sel == 2) begin
                e_txirq = ((w >> 6) & 1) && !m_tie;
                m_tie = (w >> 6) & 1;
            end
            if (ok && wr && sel == 3 && (w & 'h7F) != 'h7F) begin
                e_txv = 1; e_txd = w & 'h7F; e_txirq = m_tie;
            end
        end
        #1;
        chk("R4 rx_req", rx_req, m_pend);
        chk("R6 rx_irq", rx_irq, m_done && m_ie);
        chk("R8 tx_valid", tx_valid, e_txv);
        if (e_txv) chk("R8 tx_data", tx_data, e_txd);
        chk("R7/R8 tx_irq", tx_irq, e_txirq);
    endtask

    task automatic rd(input int a);            cyc1(1, 0, a, 0, 0, 0); endtask
    task automatic wr(input int a, input int d);  cyc1(1, 1, a, d, 0, 0); endtask
    task automatic wb(input int a, input int d);  cyc1(1, 2, a, d, 0, 0); endtask
    task automatic rx(input int d);            cyc1(0, 0, 0, 0, 1, d); endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rx_req", rx_req, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 irqs", {tx_irq, rx_irq}, 0);
        @(negedge clk); rst_n = 1'b1;
        chk("R12 pri", irq_pri, 4);
        chk("R12 vec", irq_vec, 'o64);
        rd(0); rd(4);                                   // R1 reset values
        rx('h33); rd(2);                                // R4 ignored without request
        wr(0, 'h41); rx('h5A); rd(0); rd(2); rd(0);     // R3 R4 R5 R6
        rd(1); rd(5);                                   // R2 odd word address
        wr(0, 'h41); cyc1(1, 0, 2, 0, 1, 'hA5); rd(0);  // R5 arrival with read
        wr(4, 'h40); wr(4, 'h40); wr(4, 0); wr(4, 'h40);// R7 edge only
        wr(6, 'h41); wr(6, 'h7F); wr(6, 'hFF); wr(6, 'hC2); // R8
        wr(4, 0); wr(6, 'h44);                          // R8 no irq when disabled
        wb(0, 'h41); wb(1, 'hFF); rx('h11); wb(1, 'h00); rd(0); // R9
        wb(4, 'h40); wb(5, 'hFF); wb(4, 'h00); rd(4);   // R9
        wb(6, 'h43); wb(7, 'h43); wb(6, 'h7F);          // R9 tbuf merge into zero
        rd(8); rd(14); wr(2, 1); wb(3, 1); rd(6); wr(10, 'h41); wb(12, 'h41); // R11
        wr(4, 'h40); wr(0, 'h41); rx('h77);
        cyc1(1, 3, 9, 0, 0, 0); rd(0); rd(4); rd(2);    // R10
        wr(0, 1); cyc1(1, 3, 0, 0, 1, 'h66); rd(2);     // R10 reset beats arrival
        for (int i = 0; i < 600; i++)
            cyc1($urandom % 2, $urandom % 4, $urandom % 16, $urandom % 65536,
                 $urandom % 2, $urandom % 256);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule